// File: doc/BRIEF.md
# Interrupt Entry Register Push Sequencer

This block performs the register-saving half of interrupt entry for an 8-bit processor core. When the core raises an entry request, the block takes a snapshot of the stack pointer and the register file. It then writes a nine-byte frame to memory one byte per handshake, walking downward from the current stack pointer. When the last byte has been accepted it reports the updated stack pointer. For an entry caused by an undefined opcode, on any of the four opcode pages, the return address it saves is the address of that opcode's first byte, prefix byte included. It is not the current program counter, so the handler can find the faulting instruction whatever its length.

Memory writes leave the block as a valid/ready stream. While `wr_valid_o` is high and `wr_ready_i` is low, the block holds address and data unchanged, and no byte is counted until both are high on a clock edge. The write side may stall for any number of cycles. Stalls only stretch the push. The entry request, the busy flag, the done pulse and the mask-update strobe are plain level or pulse signals with no handshake.

The core should treat the mask-update strobe as the earliest point at which it may set its interrupt-mask bits. That strobe rises only after the condition-code byte has been accepted by memory. Vector fetch and the return-from-interrupt path belong to other blocks.

Top module: `irq_stack_seq`

## Requirements
- R1: A push writes nine bytes to descending addresses S, S-1, …, S-8, where S is the stack pointer sampled with the request. The byte written at S-k, for k = 0 to 8, is in turn: return address low byte, return address high byte, IY low, IY high, IX low, IX high, accumulator A, accumulator B, condition-code byte.
- R2: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o`, `wr_addr_o` and `wr_data_o` stay unchanged on the next cycle. Exactly one byte advances per cycle in which both are high.
- R3: When `illop_i` is high with the request, the return address bytes come from `illop_pc_i`. Otherwise they come from `pc_i`.
- R4: `mask_upd_o` pulses high for exactly one cycle, on the cycle after the condition-code byte is accepted, and at no other time.
- R5: On the cycle after the final byte is accepted, `sp_o` becomes S-9 modulo 2^16 (for example, S = 0x0003 gives 0xFFFA). It holds that value until the next push completes. Writes that cross address zero wrap the same way.
- R6: `busy_o` and `wr_valid_o` are high from the cycle after an accepted request through the cycle in which the ninth byte is accepted. `done_o` pulses for one cycle right after that.
- R7: An entry request that is sampled while `busy_o` is high is ignored. It starts no push, changes no frame byte, address or `sp_o`. A request in the cycle where `done_o` is high is accepted.
- R8: After reset, `busy_o`, `wr_valid_o`, `done_o` and `mask_upd_o` are low and `sp_o` is zero.
- R9: Register, program-counter and stack-pointer inputs are sampled only on the accepted request cycle. Changes to them during a push do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_req_i | input | 1 | Interrupt entry request, sampled when idle |
| illop_i | input | 1 | Entry is caused by an undefined opcode |
| sp_i | input | 16 | Current stack pointer |
| acca_i | input | 8 | Accumulator A |
| accb_i | input | 8 | Accumulator B |
| ccr_i | input | 8 | Condition-code byte |
| ix_i | input | 16 | Index register X |
| iy_i | input | 16 | Index register Y |
| pc_i | input | 16 | Program counter of the next instruction |
| illop_pc_i | input | 16 | Address of the first byte of the undefined opcode |
| wr_valid_o | output | 1 | Write byte valid |
| wr_ready_i | input | 1 | Memory accepts the write byte |
| wr_addr_o | output | 16 | Write address |
| wr_data_o | output | 8 | Write data |
| sp_o | output | 16 | Stack pointer after the last completed push |
| busy_o | output | 1 | Push in progress |
| done_o | output | 1 | One-cycle pulse after the push completes |
| mask_upd_o | output | 1 | One-cycle pulse once the condition-code byte is written |

## Verification
The bench pushes frames whose stack pointer sits a few bytes above zero. A design that borrowed wrongly would scatter the lower bytes of the frame or report a stack pointer near 0x0000 rather than near 0xFFFA. Random back-pressure shows whether address or data slide forward on a stall, which would skip a byte or write one twice. Requests are pulsed in the middle of a push, with a different stack pointer, to catch a design that restarts or re-snapshots. A request on the done cycle catches one that drops it. Register inputs are scrambled during a push, and undefined-opcode entries are mixed with normal ones, so a design that reads live inputs or stacks the wrong return address shows up byte by byte.

// File: rtl/irq_stack_pkg.sv
package irq_stack_pkg;

  localparam int FRAME_BYTES = 9;
  localparam int SLOT_W      = $clog2(FRAME_BYTES);

  // Position of each byte in the frame, counted from the top of stack.
  typedef enum logic [SLOT_W-1:0] {
    SLOT_RET_LO = 4'd0,
    SLOT_RET_HI = 4'd1,
    SLOT_IY_LO  = 4'd2,
    SLOT_IY_HI  = 4'd3,
    SLOT_IX_LO  = 4'd4,
    SLOT_IX_HI  = 4'd5,
    SLOT_ACCA   = 4'd6,
    SLOT_ACCB   = 4'd7,
    SLOT_CCR    = 4'd8
  } slot_e;

  localparam slot_e SLOT_LAST = SLOT_CCR;

endpackage

// File: rtl/isk_ctrl.sv
module isk_ctrl
  import irq_stack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              ready_i,
  output logic              load_o,
  output logic              step_o,
  output logic              finish_o,
  output logic              busy_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              done_o,
  output logic              mask_o
);

  logic              busy_q;
  logic [SLOT_W-1:0] slot_q;
  logic              done_q;
  logic              mask_q;
  logic              accept;
  logic              at_last;

  assign accept   = busy_q & ready_i;
  assign at_last  = (slot_q == SLOT_W'(SLOT_LAST));
  assign load_o   = req_i & ~busy_q;
  assign step_o   = accept & ~at_last;
  assign finish_o = accept & at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      done_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      mask_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        slot_q <= '0;
      end else if (finish_o) begin
        busy_q <= 1'b0;
        slot_q <= '0;
        done_q <= 1'b1;
        mask_q <= 1'b1;
      end else if (step_o) begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign slot_o = slot_q;
  assign done_o = done_q;
  assign mask_o = mask_q;

endmodule

// File: rtl/isk_frame.sv
module isk_frame
  import irq_stack_pkg::*;
#(
  parameter int DW = 8,
  localparam int WW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              illop_i,
  input  logic [WW-1:0]     pc_i,
  input  logic [WW-1:0]     illop_pc_i,
  input  logic [WW-1:0]     ix_i,
  input  logic [WW-1:0]     iy_i,
  input  logic [DW-1:0]     acca_i,
  input  logic [DW-1:0]     accb_i,
  input  logic [DW-1:0]     ccr_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [DW-1:0]     data_o
);

  localparam int NWORDS = 3;

  logic [WW-1:0] words_q [NWORDS];
  logic [DW-1:0] acca_q, accb_q, ccr_q;
  logic [DW-1:0] lanes [FRAME_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) words_q[i] <= '0;
      acca_q <= '0;
      accb_q <= '0;
      ccr_q  <= '0;
    end else if (load_i) begin
      words_q[0] <= illop_i ? illop_pc_i : pc_i;
      words_q[1] <= iy_i;
      words_q[2] <= ix_i;
      acca_q     <= acca_i;
      accb_q     <= accb_i;
      ccr_q      <= ccr_i;
    end
  end

  // The word registers occupy consecutive low/high byte pairs.
  for (genvar g = 0; g < NWORDS; g++) begin : g_word_lanes
    assign lanes[2*g]   = words_q[g][DW-1:0];
    assign lanes[2*g+1] = words_q[g][WW-1:DW];
  end

  assign lanes[SLOT_ACCA] = acca_q;
  assign lanes[SLOT_ACCB] = accb_q;
  assign lanes[SLOT_CCR]  = ccr_q;

  always_comb begin
    data_o = '0;
    for (int i = 0; i < FRAME_BYTES; i++) begin
      if (slot_i == SLOT_W'(i)) data_o = lanes[i];
    end
  end

endmodule

// File: rtl/isk_addr.sv
module isk_addr
  import irq_stack_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              finish_i,
  input  logic [AW-1:0]     sp_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [AW-1:0]     addr_o,
  output logic [AW-1:0]     sp_o
);

  logic [AW-1:0] base_q;
  logic [AW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      sp_q   <= '0;
    end else begin
      if (load_i)   base_q <= sp_i;
      if (finish_i) sp_q   <= base_q - AW'(FRAME_BYTES);
    end
  end

  // Modulo-2^AW arithmetic: crossing zero simply wraps.
  assign addr_o = base_q - {{(AW-SLOT_W){1'b0}}, slot_i};
  assign sp_o   = sp_q;

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_stack_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            entry_req_i,
  input  logic            illop_i,
  input  logic [AW-1:0]   sp_i,
  input  logic [DW-1:0]   acca_i,
  input  logic [DW-1:0]   accb_i,
  input  logic [DW-1:0]   ccr_i,
  input  logic [2*DW-1:0] ix_i,
  input  logic [2*DW-1:0] iy_i,
  input  logic [2*DW-1:0] pc_i,
  input  logic [2*DW-1:0] illop_pc_i,
  output logic            wr_valid_o,
  input  logic            wr_ready_i,
  output logic [AW-1:0]   wr_addr_o,
  output logic [DW-1:0]   wr_data_o,
  output logic [AW-1:0]   sp_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            mask_upd_o
);

  logic              load;
  logic              step;
  logic              finish;
  logic              busy;
  logic [SLOT_W-1:0] slot;

  isk_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (entry_req_i),
    .ready_i  (wr_ready_i),
    .load_o   (load),
    .step_o   (step),
    .finish_o (finish),
    .busy_o   (busy),
    .slot_o   (slot),
    .done_o   (done_o),
    .mask_o   (mask_upd_o)
  );

  isk_frame #(.DW(DW)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .illop_i    (illop_i),
    .pc_i       (pc_i),
    .illop_pc_i (illop_pc_i),
    .ix_i       (ix_i),
    .iy_i       (iy_i),
    .acca_i     (acca_i),
    .accb_i     (accb_i),
    .ccr_i      (ccr_i),
    .slot_i     (slot),
    .data_o     (wr_data_o)
  );

  isk_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .finish_i (finish),
    .sp_i     (sp_i),
    .slot_i   (slot),
    .addr_o   (wr_addr_o),
    .sp_o     (sp_o)
  );

  logic unused_step;
  assign unused_step = step;

  assign wr_valid_o = busy;
  assign busy_o     = busy;

endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid_o,
  input logic          wr_ready_i,
  input logic [AW-1:0] wr_addr_o,
  input logic [DW-1:0] wr_data_o,
  input logic [AW-1:0] sp_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          mask_upd_o
);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  assert_addr_descend_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i) |=> (!wr_valid_o || wr_addr_o == $past(wr_addr_o) - AW'(1)));

  assert_mask_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_upd_o |-> $past(wr_valid_o && wr_ready_i));

  assert_mask_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_upd_o |=> !mask_upd_o);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $fell(busy_o)));

  assert_sp_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sp_o == $past(wr_addr_o) - AW'(1)));

endmodule

bind irq_stack_seq irq_stack_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .sp_o       (sp_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mask_upd_o (mask_upd_o)
);

// File: tb/irq_stack_seq_bench.sv
`timescale 1ns/1ps
module irq_stack_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, illop = 1'b0, ready = 1'b1;
  logic [15:0] sp = '0, ix = '0, iy = '0, pc = '0, illpc = '0;
  logic [7:0]  acca = '0, accb = '0, ccr = '0;
  logic        wr_valid, busy, done, mask_upd;
  logic [15:0] wr_addr, sp_out;
  logic [7:0]  wr_data;

  always #2.5 clk = ~clk;

  irq_stack_seq u_irq_stack_seq (
    .clk(clk), .rst_n(rst_n), .entry_req_i(req), .illop_i(illop),
    .sp_i(sp), .acca_i(acca), .accb_i(accb), .ccr_i(ccr), .ix_i(ix),
    .iy_i(iy), .pc_i(pc), .illop_pc_i(illpc), .wr_valid_o(wr_valid),
    .wr_ready_i(ready), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sp_o(sp_out), .busy_o(busy), .done_o(done), .mask_upd_o(mask_upd)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, dut_writes = 0, model_pushes = 0;
  bit chk_on = 0;
  string sc = "R1";

  // Reference model: a queue of {address, data} still to be written.
  logic [23:0] mq[$];
  bit          m_busy = 0, m_done = 0, m_ill = 0, m_ill_cur = 0;
  logic [15:0] m_sp = '0, m_sp_next = '0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] cycle %0d: actual 0x%0h expected 0x%0h", tag, sc, cyc, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mq.delete(); m_busy = 0; m_done = 0; m_sp = '0;
    end else begin
      m_done = 0;
      if (wr_valid && ready) dut_writes++;
      if (m_busy) begin
        if (ready) begin
          void'(mq.pop_front());
          if (mq.size() == 0) begin
            m_busy = 0; m_done = 1; m_sp = m_sp_next;
          end
        end
      end else if (req) begin
        logic [15:0] ret;
        logic [7:0]  fr [9];
        ret = illop ? illpc : pc;
        fr = '{ret[7:0], ret[15:8], iy[7:0], iy[15:8], ix[7:0], ix[15:8], acca, accb, ccr};
        for (int k = 0; k < 9; k++) mq.push_back({16'(sp - 16'(k)), fr[k]});
        m_sp_next = sp - 16'd9;
        m_busy = 1; m_ill_cur = illop; model_pushes++;
      end
    end
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_up();
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R6 valid", int'(wr_valid), int'(m_busy));
      chk("R6 busy", int'(busy), int'(m_busy));
      chk("R6 done", int'(done), int'(m_done));
      chk("R4 mask", int'(mask_upd), int'(m_done));
      chk("R5 sp", int'(sp_out), int'(m_sp));
      if (m_busy && mq.size() > 0) begin
        chk("R1 R2 addr", int'(wr_addr), int'(mq[0][23:8]));
        chk(m_ill_cur ? "R3 data" : "R1 R9 data", int'(wr_data), int'(mq[0][7:0]));
      end
    end
  end

  task automatic set_regs(logic [15:0] s, logic [15:0] base);
    sp = s; pc = base; illpc = base - 16'd2; ix = base ^ 16'h5A3C;
    iy = base ^ 16'hC3A5; acca = base[7:0] + 8'h11; accb = base[15:8] ^ 8'h77;
    ccr = base[7:0] ^ 8'hD0;
  endtask

  task automatic pulse_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    chk("R8 valid", int'(wr_valid), 0);
    chk("R8 busy", int'(busy), 0);
    chk("R8 done", int'(done), 0);
    chk("R8 mask", int'(mask_upd), 0);
    chk("R8 sp", int'(sp_out), 0);
    chk_on = 1;

    sc = "R1"; set_regs(16'h01FF, 16'hE123); pulse_req(); idle(12);

    sc = "R3"; illop = 1'b1; set_regs(16'h0400, 16'h1236); pulse_req(); illop = 1'b0; idle(12);

    sc = "R5"; set_regs(16'h0003, 16'hBEEF); pulse_req(); idle(12);
    chk("R5 wrap", int'(sp_out), 16'hFFFA);

    sc = "R2"; set_regs(16'h2000, 16'h4567);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    for (int i = 0; i < 40; i++) begin
      ready = ($urandom % 3) != 0;
      @(negedge clk);
    end
    ready = 1'b1; idle(4);

    sc = "R7"; set_regs(16'h3000, 16'h7777); pulse_req();
    idle(3); set_regs(16'h5000, 16'h9999); pulse_req();
    idle(2); pulse_req(); idle(10);
    chk("R7 sp", int'(sp_out), 16'h2FF7);
    chk("R7 writes", dut_writes, model_pushes * 9);

    sc = "R9"; illop = 1'b1; set_regs(16'h0100, 16'hA5A5); pulse_req(); illop = 1'b0;
    for (int i = 0; i < 8; i++) begin
      set_regs(16'h0F00 + 16'(i), 16'h0101 * 16'(i));
      @(negedge clk);
    end
    idle(4);

    // Request on the done cycle must start a new push (R7).
    sc = "R7 back"; set_regs(16'h0800, 16'h1357); pulse_req();
    while (!done) @(negedge clk);
    set_regs(16'h0010, 16'h2468); req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk("R7 restart", int'(busy), 1);
    idle(14);
    chk("R5 final", int'(sp_out), 16'h0007);
    chk("R7 total", dut_writes, model_pushes * 9);

    finish_up();
  end

endmodule